// File: doc/BRIEF.md
# Deferred Frame Correction Output Scheduler

This block decides when blocks from the previous frame, after a second, column-wise correction pass, are handed to the host while the current frame is still arriving. It counts received blocks with a block strobe that is qualified by a frame-start strobe. Each received-block position inside a fixed window maps to one data-block index of the previous frame. For each position the block checks a flag that records whether the first, row-wise pass already fully corrected that data block. Only blocks that still need output raise an interrupt pulse and present their index as a read address.

The flag storage has two banks. One bank collects the first-pass results for the frame now arriving. The other bank holds the results of the previous frame and drives the schedule. The two banks change roles at each frame start. The whole second pass is enabled at frame start only when frame sync is present, a previous frame exists and at least one data block of that frame is still uncorrected. If sync is lost during the pass, the rest of the pass is dropped, but block counting continues.

Skipped blocks never pull later output forward. Every data block keeps its own fixed received-block position, so a skipped block simply leaves an empty slot.

Top module: `deferred_out_sched`

## Requirements
- R1: While `rst_n` is low and after its release, `irq` is 0, `rd_idx` is 0 and `blk_num` is 0.
- R2: `blk_num` becomes 1 on a `blk_stb` cycle with `frame_start` high. It rises by one on each later `blk_stb`. On a `blk_stb` without `frame_start` at 272 it wraps to 1. It stays 0 after reset until the first frame start. `frame_start` without `blk_stb` has no effect.
- R3: When received block c (29 to 218) arrives during an enabled pass, and data block c-28 is unflagged, `irq` is high for the single cycle after that `blk_stb`. `rd_idx` is then c-28 (1-based).
- R4: `rd_idx` changes only on the cycle after a `blk_stb`. It holds 0 after any strobe that issues nothing, including received blocks 1-28 and 219-272.
- R5: A data block flagged as corrected in the first pass gets no `irq`. Later blocks keep their fixed slots (for example, with blocks 1-100 flagged, block 101 is issued at received block 129).
- R6: A pulse on `mark_we` with `mark_idx` from 1 to 190 flags that data block for the frame now arriving. The flag takes effect only in the following frame's pass. A new frame starts with no flags. A `mark_idx` of 0 or above 190 changes nothing.
- R7: A pass is enabled at frame start only if `sync_ok` is high, an earlier frame start has been seen since reset, and at least one of that frame's 190 data blocks is unflagged. Otherwise that frame issues nothing.
- R8: Once `sync_ok` is low in any cycle, no `irq` is issued for the rest of that frame, even if sync returns. `blk_num` keeps counting.
- R9: `irq` is high only in the cycle after a `blk_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_stb | input | 1 | One-cycle pulse per received block |
| frame_start | input | 1 | Qualifies `blk_stb`: this block is block 1 of a frame |
| sync_ok | input | 1 | Frame synchronization status (level) |
| mark_we | input | 1 | Write a first-pass corrected flag |
| mark_idx | input | 8 | Data block index (1-190) for `mark_we` |
| irq | output | 1 | One-cycle interrupt: a block is ready |
| rd_idx | output | 8 | Data block index to read (0 when none) |
| blk_num | output | 9 | Received block number in frame (0 before alignment) |

## Verification
The hardest state to reach from the ports is a pass in which a previous frame's flag pattern is only partly set. To get there, the stimulus must write that pattern through `mark_we` during one whole frame, then cross a frame start with sync present. The bench therefore runs a sequence of full 272-block frames, each with its own flag pattern (a low range, every block, evenly or oddly indexed blocks, plus out-of-range indices). The same frames test a sync drop in mid-pass, sync missing at frame start, and a counter wrap without a frame start. A behavioural model built from sets of flags is compared with the outputs on every clock. Separate checks count the interrupts per frame and locate the first issued block.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
   // Events decoded from one block strobe.
   typedef struct packed {
      logic frame_evt;   // strobe that starts a new frame
      logic wrap_evt;    // strobe past the last block with no frame start
      logic step_evt;    // ordinary advance of an aligned counter
   } blk_evt_t;
endpackage

// File: rtl/dfs_blk_counter.sv
module dfs_blk_counter
   import dfs_pkg::*;
#(
   parameter int FRAME_BLKS = 272,
   parameter int CNT_W      = $clog2(FRAME_BLKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blk_stb,
   input  logic             frame_start,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output blk_evt_t         evt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BLKS);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   always_comb begin
      evt.frame_evt = blk_stb && frame_start;
      evt.wrap_evt  = blk_stb && !frame_start && (cnt_q == LAST);
      evt.step_evt  = blk_stb && !frame_start && (cnt_q != LAST) && (cnt_q != '0);
      if (evt.frame_evt || evt.wrap_evt) cnt_nxt = ONE;
      else if (evt.step_evt)             cnt_nxt = cnt_q + ONE;
      else                               cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/dfs_flag_banks.sv
module dfs_flag_banks #(
   parameter int DATA_BLKS = 190,
   parameter int IDX_W     = 8,
   parameter int SEL_W     = $clog2(DATA_BLKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 swap,
   input  logic                 mark_we,
   input  logic [IDX_W-1:0]     mark_idx,
   output logic [DATA_BLKS-1:0] rd_bits,
   output logic                 fill_all_set
);
   localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(DATA_BLKS);

   logic             fill_sel_q;
   logic             wr_bank;
   logic             wr_ok;
   logic [SEL_W-1:0] wr_sel;

   assign wr_ok   = mark_we && (mark_idx != '0) && (mark_idx <= MAX_IDX);
   assign wr_sel  = SEL_W'(mark_idx - IDX_W'(1));
   assign wr_bank = swap ? ~fill_sel_q : fill_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    fill_sel_q <= 1'b0;
      else if (swap) fill_sel_q <= ~fill_sel_q;
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DATA_BLKS-1:0] bits_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits_q <= '0;
         end else begin
            if (swap && (fill_sel_q != 1'(b))) bits_q <= '0;
            if (wr_ok && (wr_bank == 1'(b)))   bits_q[wr_sel] <= 1'b1;
         end
      end
   end

   assign rd_bits      = fill_sel_q ? g_bank[0].bits_q : g_bank[1].bits_q;
   assign fill_all_set = fill_sel_q ? (&g_bank[1].bits_q) : (&g_bank[0].bits_q);
endmodule

// File: rtl/dfs_slot_map.sv
module dfs_slot_map #(
   parameter int DATA_BLKS = 190,
   parameter int OFFSET    = 28,
   parameter int CNT_W     = 9,
   parameter int IDX_W     = 8,
   parameter int SEL_W     = $clog2(DATA_BLKS)
) (
   input  logic [CNT_W-1:0]     cnt_nxt,
   input  logic [DATA_BLKS-1:0] rd_bits,
   output logic                 slot_hit,
   output logic [IDX_W-1:0]     slot_idx
);
   localparam logic [CNT_W-1:0] LO = CNT_W'(OFFSET + 1);
   localparam logic [CNT_W-1:0] HI = CNT_W'(OFFSET + DATA_BLKS);

   logic             in_win;
   logic [SEL_W-1:0] rel;

   assign in_win   = (cnt_nxt >= LO) && (cnt_nxt <= HI);
   assign rel      = SEL_W'(cnt_nxt - LO);
   assign slot_hit = in_win && !rd_bits[rel];
   assign slot_idx = IDX_W'(cnt_nxt - CNT_W'(OFFSET));
endmodule

// File: rtl/deferred_out_sched.sv
module deferred_out_sched
   import dfs_pkg::*;
#(
   parameter int FRAME_BLKS = 272,
   parameter int DATA_BLKS  = 190,
   parameter int OFFSET     = 28,
   parameter int IDX_W      = 8,
   parameter int CNT_W      = $clog2(FRAME_BLKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blk_stb,
   input  logic             frame_start,
   input  logic             sync_ok,
   input  logic             mark_we,
   input  logic [IDX_W-1:0] mark_idx,
   output logic             irq,
   output logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] blk_num
);
   if (OFFSET + DATA_BLKS > FRAME_BLKS) begin : g_bad_window
      $error("output window does not fit in a frame");
   end
   if (DATA_BLKS >= (1 << IDX_W)) begin : g_bad_idx
      $error("IDX_W too narrow for DATA_BLKS");
   end
   if (FRAME_BLKS >= (1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W too narrow for FRAME_BLKS");
   end

   blk_evt_t             evt;
   logic [CNT_W-1:0]     cnt_nxt;
   logic [DATA_BLKS-1:0] rd_bits;
   logic                 fill_all_set;
   logic                 slot_hit;
   logic [IDX_W-1:0]     slot_idx;
   logic                 pass_q;
   logic                 have_prev_q;

   dfs_blk_counter #(.FRAME_BLKS(FRAME_BLKS), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb), .frame_start(frame_start),
      .cnt_q(blk_num), .cnt_nxt(cnt_nxt), .evt(evt)
   );

   dfs_flag_banks #(.DATA_BLKS(DATA_BLKS), .IDX_W(IDX_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .swap(evt.frame_evt), .mark_we(mark_we),
      .mark_idx(mark_idx), .rd_bits(rd_bits), .fill_all_set(fill_all_set)
   );

   dfs_slot_map #(.DATA_BLKS(DATA_BLKS), .OFFSET(OFFSET), .CNT_W(CNT_W),
                  .IDX_W(IDX_W)) u_map (
      .cnt_nxt(cnt_nxt), .rd_bits(rd_bits), .slot_hit(slot_hit), .slot_idx(slot_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_q      <= 1'b0;
         have_prev_q <= 1'b0;
         irq         <= 1'b0;
         rd_idx      <= '0;
      end else begin
         irq <= 1'b0;
         if (evt.frame_evt) begin
            have_prev_q <= 1'b1;
            pass_q      <= sync_ok && have_prev_q && !fill_all_set;
         end else if (evt.wrap_evt || !sync_ok) begin
            pass_q <= 1'b0;
         end
         if (blk_stb) begin
            if (pass_q && sync_ok && slot_hit) begin
               irq    <= 1'b1;
               rd_idx <= slot_idx;
            end else begin
               rd_idx <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/dfs_sched_chk.sv
module dfs_sched_chk #(
   parameter int FRAME_BLKS = 272,
   parameter int DATA_BLKS  = 190,
   parameter int OFFSET     = 28,
   parameter int IDX_W      = 8,
   parameter int CNT_W      = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             blk_stb,
   input logic             frame_start,
   input logic             sync_ok,
   input logic             irq,
   input logic [IDX_W-1:0] rd_idx,
   input logic [CNT_W-1:0] blk_num
);
   localparam logic [CNT_W-1:0] LO   = CNT_W'(OFFSET + 1);
   localparam logic [CNT_W-1:0] HI   = CNT_W'(OFFSET + DATA_BLKS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BLKS);

   a_r9_irq_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(blk_stb));
   a_r3_idx_matches_slot: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (rd_idx == IDX_W'(blk_num - CNT_W'(OFFSET))));
   a_r4_irq_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (blk_num >= LO && blk_num <= HI));
   a_r4_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_stb |=> $stable(rd_idx));
   a_r8_no_irq_without_sync: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_ok |=> !irq);
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_stb && !frame_start && blk_num != '0 && blk_num != LAST)
         |=> (blk_num == $past(blk_num) + 1'b1));
   a_r2_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_stb && frame_start) |=> (blk_num == CNT_W'(1)));
endmodule

bind deferred_out_sched dfs_sched_chk #(
   .FRAME_BLKS(FRAME_BLKS), .DATA_BLKS(DATA_BLKS), .OFFSET(OFFSET),
   .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb), .frame_start(frame_start),
   .sync_ok(sync_ok), .irq(irq), .rd_idx(rd_idx), .blk_num(blk_num)
);

// File: tb/deferred_out_sched_tb_top.sv
`timescale 1ns/1ps
module deferred_out_sched_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       blk_stb = 1'b0;
   logic       frame_start = 1'b0;
   logic       sync_ok = 1'b1;
   logic       mark_we = 1'b0;
   logic [7:0] mark_idx = 8'd0;
   logic       irq;
   logic [7:0] rd_idx;
   logic [8:0] blk_num;

   int checks = 0;
   int errors = 0;
   string tag = "R1";
   bit done = 0;

   always #10 clk = ~clk;

   deferred_out_sched dut_i (
      .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb), .frame_start(frame_start),
      .sync_ok(sync_ok), .mark_we(mark_we), .mark_idx(mark_idx),
      .irq(irq), .rd_idx(rd_idx), .blk_num(blk_num)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit m_cur[1:190];
   bit m_prev[1:190];
   int m_cnt, m_idx;
   bit m_irq, m_pass, m_have, m_any;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_idx = 0; m_irq = 0; m_pass = 0; m_have = 0;
         for (int k = 1; k <= 190; k++) begin m_cur[k] = 0; m_prev[k] = 0; end
      end else begin
         m_irq = 0;
         if (blk_stb) begin
            if (frame_start) begin
               m_any = 0;
               for (int k = 1; k <= 190; k++) begin
                  m_prev[k] = m_cur[k];
                  if (!m_cur[k]) m_any = 1;
                  m_cur[k] = 0;
               end
               m_pass = sync_ok && m_have && m_any;
               m_have = 1;
               m_cnt = 1;
            end else if (m_cnt == 272) begin
               m_cnt = 1; m_pass = 0;
            end else if (m_cnt != 0) begin
               m_cnt++;
            end
            if (m_pass && sync_ok && m_cnt >= 29 && m_cnt <= 218 && !m_prev[m_cnt-28]) begin
               m_irq = 1; m_idx = m_cnt - 28;
            end else begin
               m_idx = 0;
            end
         end
         if (!sync_ok) m_pass = 0;
         if (mark_we && mark_idx >= 1 && mark_idx <= 190) m_cur[mark_idx] = 1;
      end
   end

   int irq_cnt = 0;
   int first_idx = -1;
   int first_blk = -1;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(blk_num == 9'(m_cnt), "R2", blk_num, m_cnt);
         chk(irq == m_irq, tag, irq, m_irq);
         chk(rd_idx == 8'(m_idx), tag, rd_idx, m_idx);
         if (irq) begin
            irq_cnt++;
            if (first_idx < 0) begin first_idx = rd_idx; first_blk = blk_num; end
         end
      end
   end

   task automatic strobe(input bit fs);
      @(negedge clk);
      blk_stb = 1'b1; frame_start = fs;
      @(negedge clk);
      blk_stb = 1'b0; frame_start = 1'b0;
   endtask

   function automatic bit want_mark(input int mode, input int b);
      case (mode)
         1: return b <= 100;
         2: return b <= 190;
         3: return b <= 190 && (b % 2 == 0);
         4: return b <= 190 && (b % 2 == 1);
         default: return 0;
      endcase
   endfunction

   // mode: flag pattern written for this frame; drop/raise: block numbers for sync changes
   task automatic run_frame(input int mode, input int drop_at, input int raise_at);
      irq_cnt = 0; first_idx = -1; first_blk = -1;
      for (int b = 1; b <= 272; b++) begin
         if (b == drop_at)  sync_ok = 1'b0;
         if (b == raise_at) sync_ok = 1'b1;
         strobe(b == 1);
         mark_we = want_mark(mode, b) || (mode == 1 && b >= 200 && b <= 202);
         mark_idx = (mode == 1 && b == 200) ? 8'd0 :
                    (mode == 1 && b == 201) ? 8'd191 :
                    (mode == 1 && b == 202) ? 8'd255 : 8'(b);
         @(negedge clk);
         mark_we = 1'b0;
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(irq == 1'b0, "R1", irq, 0);
      chk(rd_idx == 8'd0, "R1", rd_idx, 0);
      chk(blk_num == 9'd0, "R1", blk_num, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(blk_num == 9'd0 && irq == 1'b0, "R1", blk_num, 0);

      tag = "R2";
      repeat (5) strobe(1'b0);
      frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
      chk(blk_num == 9'd0, "R2", blk_num, 0);

      tag = "R7";
      run_frame(1, 0, 0);
      chk(irq_cnt == 0, "R7", irq_cnt, 0);

      tag = "R5";
      run_frame(2, 0, 0);
      chk(irq_cnt == 90, "R5", irq_cnt, 90);
      chk(first_idx == 101, "R5", first_idx, 101);
      chk(first_blk == 129, "R5", first_blk, 129);

      tag = "R7";
      run_frame(0, 0, 0);
      chk(irq_cnt == 0, "R7", irq_cnt, 0);

      tag = "R3";
      run_frame(0, 0, 0);
      chk(irq_cnt == 190, "R3", irq_cnt, 190);
      chk(first_idx == 1 && first_blk == 29, "R3", first_blk, 29);
      strobe(1'b0);
      chk(blk_num == 9'd1, "R2", blk_num, 1);
      chk(irq == 1'b0 && rd_idx == 8'd0, "R4", rd_idx, 0);

      tag = "R8";
      run_frame(3, 100, 110);
      chk(irq_cnt == 71, "R8", irq_cnt, 71);
      chk(blk_num == 9'd272, "R8", blk_num, 272);

      tag = "R7";
      run_frame(4, 1, 10);
      chk(irq_cnt == 0, "R7", irq_cnt, 0);

      tag = "R6";
      run_frame(0, 0, 0);
      chk(irq_cnt == 95, "R6", irq_cnt, 95);
      chk(first_idx == 2 && first_blk == 30, "R6", first_idx, 2);

      repeat (4) @(negedge clk);
      chk(irq == 1'b0, "R9", irq, 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule